// File: doc/BRIEF.md
# Subtract-and-Branch-if-Nonpositive Processor Core

This block is a complete processor that knows a single instruction. Each instruction is three words read from consecutive memory cells at the program counter: a source address, a target address and a jump destination. The core subtracts the source cell from the target cell and writes the difference back into the target cell. It then either jumps to the destination, when the difference is zero or negative, or moves on to the next three-word group. Code and data share one word-addressed memory that sits inside the block. With no opcode to decode, the control path is a fixed seven-step sequence of reads, one write and a program-counter update, all on a single-port synchronous RAM.

A host port writes and reads that memory while the core is stopped. The host loads a program, pulses `start`, waits for `halted` and then reads the results back. The program ends itself by taking a branch whose destination word has its sign bit set. Two counters report the clock cycles and instructions spent by the last run.

Top module: `nonpos_branch_core`

## Requirements
- R1: An instruction reads its three words from cells pc, pc+1 and pc+2 (modulo 2^ADDR_W). The source and target addresses are the low ADDR_W bits of the first two words. Every instruction takes exactly 7 clock cycles.
- R2: The target cell is overwritten with (target value − source value).
- R3: When that difference, read as signed two's complement, is zero or negative, the next pc is the low ADDR_W bits of the third word. The following three-word group is then not executed.
- R4: When the difference is positive, the next pc is pc+3 modulo 2^ADDR_W.
- R5: Subtraction wraps modulo 2^WORD_W with no trap. For example, 0x8000 − 1 stores 0x7FFF and does not branch.
- R6: A taken branch whose third word has bit WORD_W−1 set stops the core. `halted` goes high on the clock edge that ends that instruction.
- R7: An instruction whose source and target are the same zero-valued cell always jumps to its third word.
- R8: After reset, `halted` is 1 and both counters are 0. A `start` pulse while halted clears both counters and begins execution at pc 0.
- R9: The host port writes the memory only while halted. Read data appears on `host_rdata` one clock after the address. While the core runs, `host_we` and `start` have no effect.
- R10: `cycle_count` grows by one on every clock while running. `instr_count` grows by one per finished instruction. Both hold their values while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at cell 0 (only honoured while halted) |
| host_we | input | 1 | Host write enable (only honoured while halted) |
| host_addr | input | ADDR_W | Host cell address |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Memory read data, one cycle after the address |
| halted | output | 1 | Core stopped; host owns the memory |
| cycle_count | output | CNT_W | Clock cycles spent running since the last start |
| instr_count | output | CNT_W | Instructions completed since the last start |

## Verification
The bench builds the core with its default parameters: 16-bit words, 8-bit addresses and 32-bit counters. With these values the edge case 0x8000 − 1 is reachable, as is an address space small enough to sweep every data cell after each run. Halting is tested with more than one negative destination word, 0xFFFF and 0x8005. A behavioural model steps the same programs cycle by cycle. It covers a countdown loop built on unconditional jumps, a skipped instruction after a taken branch, and host writes and restarts attempted mid-run.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
   typedef enum logic [2:0] {
      ST_HALT    = 3'd0,
      ST_FETCH_A = 3'd1,
      ST_FETCH_B = 3'd2,
      ST_FETCH_C = 3'd3,
      ST_READ_A  = 3'd4,
      ST_READ_B  = 3'd5,
      ST_WRITE_B = 3'd6,
      ST_UPD_PC  = 3'd7
   } nbc_state_e;
endpackage

// File: rtl/nbc_ram.sv
module nbc_ram #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] cells [DEPTH];

   // single port, read-before-write
   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
      rdata <= cells[addr];
   end
endmodule

// File: rtl/nbc_subtract.sv
module nbc_subtract #(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] minuend,
   input  logic [WORD_W-1:0] subtrahend,
   output logic [WORD_W-1:0] diff,
   output logic              nonpos
);
   // wraps modulo 2^WORD_W; sign bit or all-zero means "not positive"
   always_comb begin
      diff   = minuend - subtrahend;
      nonpos = diff[WORD_W-1] | (diff == '0);
   end
endmodule

// File: rtl/nbc_seq.sv
module nbc_seq
   import nbc_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              nonpos,
   output logic [ADDR_W-1:0] core_addr,
   output logic              core_we,
   output logic [WORD_W-1:0] val_a,
   output logic              halted,
   output logic [CNT_W-1:0]  cycle_count,
   output logic [CNT_W-1:0]  instr_count
);
   localparam logic [ADDR_W-1:0] ADDR_ONE   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_TWO   = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] ADDR_THREE = ADDR_W'(3);
   localparam logic [CNT_W-1:0]  CNT_ONE    = CNT_W'(1);

   nbc_state_e        state;
   logic [ADDR_W-1:0] pc, op_a, op_b, op_c_addr;
   logic              op_c_neg, nonpos_q;
   logic              unused_ok;

   assign unused_ok = ^mem_rdata;
   assign halted    = (state == ST_HALT);
   assign core_we   = (state == ST_WRITE_B);

   always_comb begin
      unique case (state)
         ST_FETCH_A: core_addr = pc;
         ST_FETCH_B: core_addr = pc + ADDR_ONE;
         ST_FETCH_C: core_addr = pc + ADDR_TWO;
         ST_READ_A:  core_addr = op_a;
         ST_READ_B,
         ST_WRITE_B: core_addr = op_b;
         default:    core_addr = pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_HALT;
         pc          <= '0;
         op_a        <= '0;
         op_b        <= '0;
         op_c_addr   <= '0;
         op_c_neg    <= 1'b0;
         val_a       <= '0;
         nonpos_q    <= 1'b0;
         cycle_count <= '0;
         instr_count <= '0;
      end else begin
         if (state != ST_HALT) cycle_count <= cycle_count + CNT_ONE;
         unique case (state)
            ST_HALT: if (start) begin
               state       <= ST_FETCH_A;
               pc          <= '0;
               cycle_count <= '0;
               instr_count <= '0;
            end
            ST_FETCH_A: state <= ST_FETCH_B;
            ST_FETCH_B: begin
               op_a  <= mem_rdata[ADDR_W-1:0];
               state <= ST_FETCH_C;
            end
            ST_FETCH_C: begin
               op_b  <= mem_rdata[ADDR_W-1:0];
               state <= ST_READ_A;
            end
            ST_READ_A: begin
               op_c_addr <= mem_rdata[ADDR_W-1:0];
               op_c_neg  <= mem_rdata[WORD_W-1];
               state     <= ST_READ_B;
            end
            ST_READ_B: begin
               val_a <= mem_rdata;
               state <= ST_WRITE_B;
            end
            ST_WRITE_B: begin
               nonpos_q <= nonpos;
               state    <= ST_UPD_PC;
            end
            ST_UPD_PC: begin
               instr_count <= instr_count + CNT_ONE;
               if (nonpos_q && op_c_neg) begin
                  state <= ST_HALT;
               end else begin
                  pc    <= nonpos_q ? op_c_addr : pc + ADDR_THREE;
                  state <= ST_FETCH_A;
               end
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   // R1: fetch phase is followed by the next fetch step
   a_r1_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FETCH_A |=> state == ST_FETCH_B);
   // R2: write-back is always followed by the pc update
   a_r2_wb_then_pc: assert property (@(posedge clk) disable iff (!rst_n)
      core_we |=> state == ST_UPD_PC);
   // R4: a positive result falls through by three cells
   a_r4_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_UPD_PC && !nonpos_q) |=> pc == $past(pc) + ADDR_THREE);
   // R6: taken branch with negative destination stops the core
   a_r6_halt_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_UPD_PC && nonpos_q && op_c_neg) |=> halted);
   // R10: cycle counter advances every running clock
   a_r10_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
      !halted |=> cycle_count == $past(cycle_count) + CNT_ONE);
endmodule

// File: rtl/nonpos_branch_core.sv
module nonpos_branch_core #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic              halted,
   output logic [CNT_W-1:0]  cycle_count,
   output logic [CNT_W-1:0]  instr_count
);
   generate
      if (ADDR_W < 2 || ADDR_W >= WORD_W) begin : g_bad_addr_w
         $error("ADDR_W must be at least 2 and below WORD_W");
      end
      if (CNT_W < 8) begin : g_bad_cnt_w
         $error("CNT_W must be at least 8");
      end
   endgenerate

   logic [ADDR_W-1:0] core_addr, mem_addr;
   logic              core_we, mem_we, nonpos;
   logic [WORD_W-1:0] mem_rdata, mem_wdata, val_a, diff;

   // host owns the memory whenever the core is stopped
   always_comb begin
      mem_we    = halted ? host_we    : core_we;
      mem_addr  = halted ? host_addr  : core_addr;
      mem_wdata = halted ? host_wdata : diff;
   end
   assign host_rdata = mem_rdata;

   nbc_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
   );

   nbc_subtract #(.WORD_W(WORD_W)) u_sub (
      .minuend(mem_rdata), .subtrahend(val_a), .diff(diff), .nonpos(nonpos)
   );

   nbc_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
      .nonpos(nonpos), .core_addr(core_addr), .core_we(core_we), .val_a(val_a),
      .halted(halted), .cycle_count(cycle_count), .instr_count(instr_count)
   );

   // R8: a stopped core stays stopped until started
   a_r8_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !start) |=> halted);
   // R10: instruction count frozen while stopped
   a_r10_instr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !start) |=> $stable(instr_count));
   // R9: no write reaches memory from the host while running
   a_r9_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && mem_we) |-> mem_addr == core_addr);
endmodule

// File: tb/nonpos_branch_core_tb_top.sv
module nonpos_branch_core_tb_top;
   localparam int W = 16;
   localparam int A = 8;
   localparam int N = 1 << A;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         host_we = 1'b0;
   logic [A-1:0] host_addr = '0;
   logic [W-1:0] host_wdata = '0;
   logic [W-1:0] host_rdata;
   logic         halted;
   logic [31:0]  cycle_count, instr_count;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;

   always #5 clk = ~clk;

   nonpos_branch_core dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .halted(halted), .cycle_count(cycle_count), .instr_count(instr_count)
   );

   // ---------------- behavioural reference model ----------------
   logic [W-1:0] m_mem [N];
   bit           m_run;
   int           m_pc, m_ph;
   logic [31:0]  m_cc, m_ic;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_cc = 0; m_ic = 0; m_pc = 0; m_ph = 0;
      end else if (m_run) begin
         m_cc = m_cc + 1;
         m_ph = m_ph + 1;
         if (m_ph == 7) begin
            int ia, ib;
            logic [W-1:0] c, r;
            ia = int'(m_mem[m_pc] % N);
            ib = int'(m_mem[(m_pc + 1) % N] % N);
            c  = m_mem[(m_pc + 2) % N];
            r  = m_mem[ib] - m_mem[ia];
            m_mem[ib] = r;
            m_ic = m_ic + 1;
            m_ph = 0;
            if (r == 0 || r[W-1]) begin
               if (c[W-1]) m_run = 0;
               else m_pc = int'(c % N);
            end else m_pc = (m_pc + 3) % N;
         end
      end else begin
         if (host_we) m_mem[host_addr] = host_wdata;
         if (start) begin
            m_run = 1; m_pc = 0; m_cc = 0; m_ic = 0; m_ph = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison (R6, R10)
   always @(negedge clk) begin
      if (cmp_en) begin
         chk(halted == !m_run, "R6", "halted vs model", halted, !m_run);
         chk(cycle_count == m_cc, "R10", "cycle_count vs model", cycle_count, m_cc);
         chk(instr_count == m_ic, "R10", "instr_count vs model", instr_count, m_ic);
      end
   end

   // all tasks start and end at a falling edge
   task automatic hw(input int a, input logic [W-1:0] d);
      host_addr = A'(a); host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hr(input int a, output logic [W-1:0] d);
      host_addr = A'(a);
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic run(input bit inject);
      int n = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!halted && n < 5000) begin
         n++;
         if (inject && n == 10) begin
            start = 1'b1; host_we = 1'b1; host_addr = A'(140); host_wdata = 16'h0055;
         end else begin
            start = 1'b0; host_we = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0; host_we = 1'b0;
      chk(halted, "R6", "run reached halt", halted, 1);
      chk(cycle_count == 7 * instr_count, "R1", "7 cycles per instruction",
          cycle_count, 7 * instr_count);
   endtask

   task automatic sweep(input string req);
      int bad = 0;
      logic [W-1:0] d;
      for (int i = 0; i < 160; i++) begin
         hr(i, d);
         if (d !== m_mem[i]) begin
            if (bad == 0)
               $display("FAIL %s memory cell %0d: actual %0h expected %0h", req, i, d, m_mem[i]);
            bad++;
         end
      end
      checks++;
      if (bad != 0) errors++;
   endtask

   task automatic expect_cell(input int a, input logic [W-1:0] e, input string req);
      logic [W-1:0] d;
      hr(a, d);
      chk(d === e, req, $sformatf("cell %0d", a), d, e);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(halted == 1'b1, "R8", "halted in reset", halted, 1);
      chk(cycle_count == 0 && instr_count == 0, "R8", "counters in reset",
          cycle_count + instr_count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1'b1;
      for (int i = 0; i < N; i++) hw(i, '0);

      // P1: positive result falls through, then Z Z halt
      hw(0, 100); hw(1, 101); hw(2, 3);
      hw(3, 102); hw(4, 102); hw(5, 16'hFFFF);
      hw(100, 3); hw(101, 10); hw(102, 0);
      run(0);
      chk(instr_count == 2, "R4", "P1 instructions", instr_count, 2);
      expect_cell(101, 16'd7, "R2");
      sweep("R2");

      // P2: countdown loop with unconditional jumps; mid-run host write and start
      hw(0, 111); hw(1, 110); hw(2, 9);
      hw(3, 113); hw(4, 112); hw(5, 6);
      hw(6, 114); hw(7, 114); hw(8, 0);
      hw(9, 114); hw(10, 114); hw(11, 16'hFFFF);
      hw(110, 5); hw(111, 1); hw(112, 0); hw(113, 16'hFFFC); hw(114, 0); hw(140, 0);
      run(1);
      chk(instr_count == 14, "R7", "P2 instructions", instr_count, 14);
      chk(cycle_count == 98, "R8", "start cleared counters, R9 restart ignored",
          cycle_count, 98);
      expect_cell(112, 16'd16, "R7");
      expect_cell(140, 16'd0, "R9");
      sweep("R3");

      // P3: wrap-around subtraction
      hw(0, 121); hw(1, 120); hw(2, 3);
      hw(3, 122); hw(4, 122); hw(5, 16'hFFFF);
      hw(120, 16'h8000); hw(121, 1); hw(122, 0);
      run(0);
      expect_cell(120, 16'h7FFF, "R5");
      chk(instr_count == 2, "R5", "no branch on wrap", instr_count, 2);

      // P4: negative result branches, skipped instruction leaves its target
      hw(0, 130); hw(1, 131); hw(2, 6);
      hw(3, 132); hw(4, 133); hw(5, 9);
      hw(6, 134); hw(7, 134); hw(8, 16'h8005);
      hw(130, 5); hw(131, 2); hw(132, 1); hw(133, 50); hw(134, 0);
      run(0);
      expect_cell(131, 16'hFFFD, "R3");
      expect_cell(133, 16'd50, "R3");
      chk(instr_count == 2, "R3", "P4 instructions", instr_count, 2);
      sweep("R4");

      // R10: counters hold while halted
      repeat (5) @(negedge clk);
      chk(instr_count == 2 && cycle_count == 14, "R10", "counters hold",
          cycle_count, 14);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule